// File: doc/BRIEF.md
# Delayed Read Transaction Tracker

This block sits on the target side of a conventional PCI bridge. It handles inbound reads as delayed transactions. Each request presented to it is first checked against a programmable inbound address window. A request that falls inside the window is compared with up to eight pending reads held in a request table. The block then answers with a one-cycle response code: not claimed, Retry, data follows, or empty completion. A claimed request that matches nothing takes a free table slot, and the block issues a delayed read toward the internal side tagged with that slot number.

The internal side returns quadwords tagged with the slot number. A quadword marked as aborted is never stored. When a later request matches a slot whose fetch has finished, the block streams the stored words to the initiator, one word for each cycle the initiator is ready. It flags the last stored word as a disconnect-with-data. If the initiator stops early, the unread words are discarded. In both cases the slot is freed so that it can take a new request on the next cycle.

A configuration bit selects how strictly requests are compared. In strict mode the full address and the command must both be equal. In aliased mode only the address bits at and above a programmable line offset are compared, and the command is ignored.

Top module: `dlyrd_tracker`

## Requirements
- R1: A request with address below the effective base or above `cfg_limit` is answered with rsp_code 0 (not claimed) and launches no internal read.
- R2: For a dual-address request (`req_dac`=1) the effective base is {`cfg_base_hi`,`cfg_base_lo`}. For a single-address request it is {0,`cfg_base_lo`}.
- R3: A claimed request that matches no held entry, while a slot is free, is answered with rsp_code 1 (Retry). In the same cycle it raises `dreq_valid` for one cycle, carrying the request address, the command and the lowest free slot number as tag.
- R4: A claimed request that matches a held entry whose fetch has not finished is answered with Retry and launches nothing.
- R5: A claimed request that matches a held entry whose fetch finished with at least one stored word is answered with rsp_code 2 (data) and raises `xfer_busy`.
- R6: A claimed request that matches nothing while all eight slots are held is answered with Retry, launches nothing and captures nothing.
- R7: During a burst, each cycle with `mst_rdy` high yields the next stored word on `dout_data` one cycle later, in fill order. The final stored word carries `dout_last`, and `xfer_busy` falls in the same cycle.
- R8: `mst_stop` during a burst ends it and discards the unread words. The slot is freed, so the same request afterwards is a miss and is launched again.
- R9: A returned word with `fill_abort`=1 is not stored and never appears on `dout_data`.
- R10: With `cfg_alias`=0 a match needs equal full address and equal command. With `cfg_alias`=1 a match needs only equal address bits from ALIAS_LSB upward (default 5), and the command is ignored.
- R11: A slot freed by a completed burst takes a new request on the next request.
- R12: `rsp_valid` is high exactly one cycle after each request accepted while not busy, and low otherwise.
- R13: A matching entry whose fetch finished with no stored word is answered with rsp_code 3 (empty) and its slot is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_lo | input | LW | Low part of inbound window base |
| cfg_base_hi | input | AW-LW | Upper base part, used for dual-address requests |
| cfg_limit | input | AW | Highest claimed address |
| cfg_alias | input | 1 | 1 = aliased line compare, 0 = full address and command compare |
| req_valid | input | 1 | Request strobe, one cycle |
| req_addr | input | AW | Request address |
| req_dac | input | 1 | Request is a dual-address cycle |
| req_cmd | input | CMD_W | Request command |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 not claimed, 1 Retry, 2 data, 3 empty |
| dreq_valid | output | 1 | Delayed read launch strobe |
| dreq_tag | output | TW | Slot number of launched read |
| dreq_addr | output | AW | Launched read address |
| dreq_cmd | output | CMD_W | Launched read command |
| fill_valid | input | 1 | Returned word strobe |
| fill_tag | input | TW | Slot number of returned word |
| fill_data | input | DW | Returned quadword |
| fill_abort | input | 1 | Word ended in target abort, drop it |
| fill_last | input | 1 | Final word of this fetch |
| mst_rdy | input | 1 | Initiator takes a word this cycle |
| mst_stop | input | 1 | Initiator ends the burst |
| xfer_busy | output | 1 | Burst in progress |
| dout_valid | output | 1 | Burst word strobe |
| dout_data | output | DW | Burst word |
| dout_last | output | 1 | Disconnect with data on this word |

## Verification
The assertions assume that requests arrive only while `xfer_busy` is low. They also assume that the internal side returns words only for slots it has been handed and that are still awaiting data, and never more than WORDS words per fetch. Single-address requests are assumed to carry a zero upper address half. The directed stimulus keeps to all of these assumptions. It issues every request from an idle bus, fills only tags seen on `dreq_tag`, and uses at most three words per fetch.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_RETRY = 2'd1,
    RSP_DATA  = 2'd2,
    RSP_EMPTY = 2'd3
  } rsp_e;
endpackage

// File: rtl/dlyrd_window.sv
module dlyrd_window #(
  parameter int AW = 64,
  parameter int LW = 32
) (
  input  logic [AW-1:0]    addr,
  input  logic             dac,
  input  logic [LW-1:0]    base_lo,
  input  logic [AW-LW-1:0] base_hi,
  input  logic [AW-1:0]    limit,
  output logic             hit
);
  logic [AW-1:0] eff_base;
  always_comb begin
    eff_base = {(dac ? base_hi : {(AW-LW){1'b0}}), base_lo};
    hit      = (addr >= eff_base) && (addr <= limit);
  end
endmodule

// File: rtl/dlyrd_match.sv
module dlyrd_match #(
  parameter int AW        = 64,
  parameter int CMD_W     = 4,
  parameter int DEPTH     = 8,
  parameter int ALIAS_LSB = 5
) (
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][AW-1:0]    ent_addr,
  input  logic [DEPTH-1:0][CMD_W-1:0] ent_cmd,
  input  logic [AW-1:0]               addr,
  input  logic [CMD_W-1:0]            cmd,
  input  logic                        alias_mode,
  output logic [DEPTH-1:0]            hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic full_eq, line_eq;
    always_comb begin
      full_eq = (ent_addr[g] == addr) && (ent_cmd[g] == cmd);
      line_eq = (ent_addr[g][AW-1:ALIAS_LSB] == addr[AW-1:ALIAS_LSB]);
      hit[g]  = vld[g] && (alias_mode ? line_eq : full_eq);
    end
  end
endmodule

// File: rtl/dlyrd_rdbuf.sv
module dlyrd_rdbuf #(
  parameter int DW = 64,
  parameter int NW = 32,
  localparam int BW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [BW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NW];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dlyrd_tracker.sv
module dlyrd_tracker
  import dlyrd_pkg::*;
#(
  parameter int AW        = 64,
  parameter int LW        = 32,
  parameter int CMD_W     = 4,
  parameter int DEPTH     = 8,
  parameter int WORDS     = 4,
  parameter int DW        = 64,
  parameter int ALIAS_LSB = 5,
  localparam int TW = $clog2(DEPTH),
  localparam int IW = $clog2(WORDS),
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LW-1:0]    cfg_base_lo,
  input  logic [AW-LW-1:0] cfg_base_hi,
  input  logic [AW-1:0]    cfg_limit,
  input  logic             cfg_alias,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_dac,
  input  logic [CMD_W-1:0] req_cmd,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic             dreq_valid,
  output logic [TW-1:0]    dreq_tag,
  output logic [AW-1:0]    dreq_addr,
  output logic [CMD_W-1:0] dreq_cmd,
  input  logic             fill_valid,
  input  logic [TW-1:0]    fill_tag,
  input  logic [DW-1:0]    fill_data,
  input  logic             fill_abort,
  input  logic             fill_last,
  input  logic             mst_rdy,
  input  logic             mst_stop,
  output logic             xfer_busy,
  output logic             dout_valid,
  output logic [DW-1:0]    dout_data,
  output logic             dout_last
);
  // slot table
  logic [DEPTH-1:0]            ent_vld, ent_done;
  logic [DEPTH-1:0][AW-1:0]    ent_addr;
  logic [DEPTH-1:0][CMD_W-1:0] ent_cmd;
  logic [DEPTH-1:0][CW-1:0]    ent_cnt;

  // burst state
  logic [TW-1:0] b_tag;
  logic [CW-1:0] b_idx;

  logic             claim;
  logic [DEPTH-1:0] hit;
  logic             hit_any, full;
  logic [TW-1:0]    hit_idx, free_idx;
  logic             req_go, capture;
  logic             fill_ok, fill_wr;
  logic             rd_go, rd_end;

  function automatic logic [TW-1:0] lowest_set(input logic [DEPTH-1:0] v);
    lowest_set = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (v[i]) lowest_set = TW'(i);
  endfunction

  dlyrd_window #(.AW(AW), .LW(LW)) win_i (
    .addr(req_addr), .dac(req_dac), .base_lo(cfg_base_lo),
    .base_hi(cfg_base_hi), .limit(cfg_limit), .hit(claim)
  );

  dlyrd_match #(.AW(AW), .CMD_W(CMD_W), .DEPTH(DEPTH), .ALIAS_LSB(ALIAS_LSB)) cmp_i (
    .vld(ent_vld), .ent_addr(ent_addr), .ent_cmd(ent_cmd),
    .addr(req_addr), .cmd(req_cmd), .alias_mode(cfg_alias), .hit(hit)
  );

  always_comb begin
    hit_any  = |hit;
    hit_idx  = lowest_set(hit);
    full     = &ent_vld;
    free_idx = lowest_set(~ent_vld);
    req_go   = req_valid && !xfer_busy;
    capture  = req_go && claim && !hit_any && !full;
    fill_ok  = fill_valid && ent_vld[fill_tag] && !ent_done[fill_tag];
    fill_wr  = fill_ok && !fill_abort && (ent_cnt[fill_tag] < CW'(WORDS));
    rd_go    = xfer_busy && mst_rdy && !mst_stop;
    rd_end   = rd_go && ((b_idx + CW'(1)) == ent_cnt[b_tag]);
  end

  dlyrd_rdbuf #(.DW(DW), .NW(DEPTH * WORDS)) buf_i (
    .clk(clk),
    .we(fill_wr),
    .waddr({fill_tag, ent_cnt[fill_tag][IW-1:0]}),
    .wdata(fill_data),
    .re(rd_go),
    .raddr({b_tag, b_idx[IW-1:0]}),
    .rdata(dout_data)
  );

  // payload fields, no reset needed
  always_ff @(posedge clk) begin
    if (capture) begin
      ent_addr[free_idx] <= req_addr;
      ent_cmd[free_idx]  <= req_cmd;
      dreq_addr          <= req_addr;
      dreq_cmd           <= req_cmd;
      dreq_tag           <= free_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld    <= '0;
      ent_done   <= '0;
      ent_cnt    <= '0;
      rsp_valid  <= 1'b0;
      rsp_code   <= RSP_NONE;
      dreq_valid <= 1'b0;
      xfer_busy  <= 1'b0;
      b_tag      <= '0;
      b_idx      <= '0;
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
    end else begin
      rsp_valid  <= req_go;
      dreq_valid <= capture;
      dout_valid <= rd_go;
      dout_last  <= rd_end;

      if (req_go) begin
        if (!claim) begin
          rsp_code <= RSP_NONE;
        end else if (hit_any) begin
          if (!ent_done[hit_idx]) begin
            rsp_code <= RSP_RETRY;
          end else if (ent_cnt[hit_idx] == '0) begin
            rsp_code         <= RSP_EMPTY;
            ent_vld[hit_idx] <= 1'b0;
          end else begin
            rsp_code  <= RSP_DATA;
            xfer_busy <= 1'b1;
            b_tag     <= hit_idx;
            b_idx     <= '0;
          end
        end else begin
          rsp_code <= RSP_RETRY;
          if (!full) begin
            ent_vld[free_idx]  <= 1'b1;
            ent_done[free_idx] <= 1'b0;
            ent_cnt[free_idx]  <= '0;
          end
        end
      end

      if (fill_wr) ent_cnt[fill_tag] <= ent_cnt[fill_tag] + CW'(1);
      if (fill_ok && fill_last) ent_done[fill_tag] <= 1'b1;

      if (xfer_busy && mst_stop) begin
        xfer_busy      <= 1'b0;
        ent_vld[b_tag] <= 1'b0;
      end else if (rd_go) begin
        b_idx <= b_idx + CW'(1);
        if (rd_end) begin
          xfer_busy      <= 1'b0;
          ent_vld[b_tag] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dlyrd_tracker_chk.sv
module dlyrd_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       dreq_valid,
  input logic       xfer_busy,
  input logic       dout_valid,
  input logic       dout_last
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xfer_busy) |=> rsp_valid); // R12
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid)); // R12
  AST_LAUNCH_WITH_RETRY: assert property (@(posedge clk) disable iff (rst)
    dreq_valid |-> (rsp_valid && rsp_code == 2'd1)); // R3
  AST_NOCLAIM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd0) |-> !dreq_valid); // R1
  AST_DATA_OPENS_BURST: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd2) |-> xfer_busy); // R5
  AST_WORD_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(xfer_busy)); // R7
  AST_LAST_CLOSES_BURST: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && dout_last) |-> !xfer_busy); // R7
endmodule

bind dlyrd_tracker dlyrd_tracker_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .dreq_valid(dreq_valid), .xfer_busy(xfer_busy),
  .dout_valid(dout_valid), .dout_last(dout_last)
);

// File: tb/dlyrd_tracker_tb_top.sv
`timescale 1ns/1ps
module dlyrd_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base_lo = 32'h1000_0000;
  logic [31:0] cfg_base_hi = 32'h1;
  logic [63:0] cfg_limit   = 64'h1_1FFF_FFFF;
  logic        cfg_alias = 1'b0;
  logic        req_valid = 1'b0, req_dac = 1'b0;
  logic [63:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic        dreq_valid;
  logic [2:0]  dreq_tag;
  logic [63:0] dreq_addr;
  logic [3:0]  dreq_cmd;
  logic        fill_valid = 1'b0, fill_abort = 1'b0, fill_last = 1'b0;
  logic [2:0]  fill_tag = '0;
  logic [63:0] fill_data = '0;
  logic        mst_rdy = 1'b0, mst_stop = 1'b0;
  logic        xfer_busy, dout_valid, dout_last;
  logic [63:0] dout_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dlyrd_tracker dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(logic [63:0] a, logic dac, logic [3:0] c,
                        logic [1:0] exp_code, logic exp_launch,
                        logic [2:0] exp_tag, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_dac = dac; req_cmd = c;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, rsp_valid, 1'b1);
    chk({tag, " rsp_code"}, rsp_code, exp_code);
    chk({tag, " launch"}, dreq_valid, exp_launch);
    if (exp_launch) chk({tag, " tag"}, dreq_tag, exp_tag);
    @(negedge clk);
    chk("R12 rsp single cycle", rsp_valid, 1'b0);
  endtask

  task automatic fill(logic [2:0] t, logic [63:0] d, logic ab, logic last);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_data = d; fill_abort = ab; fill_last = last;
    @(negedge clk);
    fill_valid = 1'b0; fill_abort = 1'b0; fill_last = 1'b0;
  endtask

  task automatic pull(logic [63:0] exp_d, logic exp_last, string tag);
    mst_rdy = 1'b1;
    @(negedge clk);
    mst_rdy = 1'b0;
    chk({tag, " dout_valid"}, dout_valid, 1'b1);
    chk({tag, " dout_data"}, dout_data, exp_d);
    chk({tag, " dout_last"}, dout_last, exp_last);
    chk({tag, " busy"}, xfer_busy, !exp_last);
  endtask

  task automatic t_reset();
    chk("R12 reset rsp_valid", rsp_valid, 1'b0);
    chk("R7 reset busy", xfer_busy, 1'b0);
    chk("R3 reset dreq", dreq_valid, 1'b0);
    chk("R7 reset dout", dout_valid, 1'b0);
  endtask

  task automatic t_window();
    do_req(64'h0FFF_FFF8, 1'b0, 4'h6, 2'd0, 1'b0, 3'd0, "R1 below base");
    do_req(64'h1_2000_0000, 1'b1, 4'h6, 2'd0, 1'b0, 3'd0, "R1 above limit");
  endtask

  task automatic t_capture();
    do_req(64'h1000_0040, 1'b0, 4'h6, 2'd1, 1'b1, 3'd0, "R3 miss launch");
    @(negedge clk);
    do_req(64'h1000_0040, 1'b0, 4'h6, 2'd1, 1'b0, 3'd0, "R4 match pending");
  endtask

  task automatic t_capture_addr();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h1000_0180; req_dac = 1'b0; req_cmd = 4'hE;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 dreq_addr", dreq_addr, 64'h1000_0180);
    chk("R3 dreq_cmd", dreq_cmd, 4'hE);
  endtask

  task automatic t_dac();
    do_req(64'h1_1000_0080, 1'b1, 4'h6, 2'd1, 1'b1, 3'd1, "R2 dac upper base");
    do_req(64'h0_1000_0080, 1'b1, 4'h6, 2'd0, 1'b0, 3'd0, "R2 dac below base");
  endtask

  task automatic t_burst();
    fill(3'd0, 64'hD0D0, 1'b0, 1'b0);
    fill(3'd0, 64'hBAD1, 1'b1, 1'b0);
    fill(3'd0, 64'hD2D2, 1'b0, 1'b1);
    do_req(64'h1000_0040, 1'b0, 4'h6, 2'd2, 1'b0, 3'd0, "R5 data ready");
    chk("R5 busy", xfer_busy, 1'b1);
    pull(64'hD0D0, 1'b0, "R7 word0");
    pull(64'hD2D2, 1'b1, "R9 abort skipped last");
    do_req(64'h1000_0100, 1'b0, 4'h6, 2'd1, 1'b1, 3'd0, "R11 slot reused");
  endtask

  task automatic t_alias();
    do_req(64'h1000_0108, 1'b0, 4'h6, 2'd1, 1'b1, 3'd2, "R10 strict miss");
    cfg_alias = 1'b1;
    do_req(64'h1000_0110, 1'b0, 4'hC, 2'd1, 1'b0, 3'd0, "R10 aliased match");
    cfg_alias = 1'b0;
  endtask

  task automatic t_full();
    for (int k = 0; k < 5; k++)
      do_req(64'h1000_1000 + 64'(k) * 64'h40, 1'b0, 4'h6, 2'd1, 1'b1, 3'(k + 3), "R6 fill table");
    do_req(64'h1000_2000, 1'b0, 4'h6, 2'd1, 1'b0, 3'd0, "R6 full miss");
    do_req(64'h1000_2000, 1'b0, 4'h6, 2'd1, 1'b0, 3'd0, "R6 full miss again");
  endtask

  task automatic t_stop();
    fill(3'd1, 64'hB0, 1'b0, 1'b0);
    fill(3'd1, 64'hB1, 1'b0, 1'b0);
    fill(3'd1, 64'hB2, 1'b0, 1'b1);
    do_req(64'h1_1000_0080, 1'b1, 4'h6, 2'd2, 1'b0, 3'd0, "R8 data");
    pull(64'hB0, 1'b0, "R8 word0");
    mst_stop = 1'b1;
    @(negedge clk);
    mst_stop = 1'b0;
    chk("R8 stop ends burst", xfer_busy, 1'b0);
    chk("R8 no word on stop", dout_valid, 1'b0);
    do_req(64'h1_1000_0080, 1'b1, 4'h6, 2'd1, 1'b1, 3'd1, "R8 flushed relaunch");
  endtask

  task automatic t_empty();
    fill(3'd3, 64'hDEAD, 1'b1, 1'b1);
    do_req(64'h1000_1000, 1'b0, 4'h6, 2'd3, 1'b0, 3'd0, "R13 empty");
    chk("R13 no burst", xfer_busy, 1'b0);
    do_req(64'h1000_1000, 1'b0, 4'h6, 2'd1, 1'b1, 3'd3, "R13 freed relaunch");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_capture();
    t_dac();
    t_burst();
    t_alias();
    t_full();
    t_stop();
    t_empty();
    // slot 4 free after the stop test? no: table is full again, so use a fresh reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_capture_addr();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule